// File: doc/BRIEF.md
# Byte Lane Write Strobe and Output Drive Control

This block sits beside a synchronous memory with a 36-bit common data port. The port is split into four byte lanes, and each lane carries eight data bits and one parity bit. On every rising clock edge the block registers the write controls, which are all active low: a whole-word write request, a byte-write enable and one select per lane. From them it produces four lane write strobes and a 36-bit per-bit write enable. On the same edge it captures the incoming write word. The memory array can then commit the registered word under the registered strobes during the following cycle.

The block also produces the enable for the tri-state drivers on the data pins. That enable follows an asynchronous active-low output enable. It is forced off when the registered cycle is a write, when the device is deselected, and for the first read cycle that follows a deselected state. Chip selection is sampled only on cycles where a new address is loaded, and it is held in all other cycles. Every interface here is a plain per-cycle control signal. The block accepts one cycle on every edge and never applies back-pressure.

Top module: `byte_write_drive_ctrl`

## Requirements
- R1: During and after reset, until the first clock edge with reset released, every lane strobe, every bit write enable and the drive enable are 0, and the design is deselected.
- R2: In a selected cycle with `word_wr_n` low at the edge, all four lane strobes are 1 in the following cycle, whatever `byte_wr_n` and `lane_sel_n` are.
- R3: In a selected cycle with `word_wr_n` high and `byte_wr_n` low, lane strobe k is 1 in the following cycle exactly when `lane_sel_n[k]` was low. With both write controls high the cycle is a read and no strobe is set.
- R4: Lane k owns data bits 8k to 8k+7 and parity bit 32+k of `bit_we`. All nine bits equal lane strobe k.
- R5: When no other condition forces the drivers off, `drive_en` is the inverse of `oe_n` and follows it within the same cycle, with no clock edge in between.
- R6: In the cycle after an edge that registered a write, `drive_en` is 0 whatever `oe_n` is.
- R7: Selection is updated only when `addr_load` is high, taking the value of `cs_n` low. When `addr_load` is low the previous selection is kept. In a deselected cycle there are no strobes and `drive_en` is 0.
- R8: For a read registered at an edge where the previous state was deselected, `drive_en` is 0 for that one cycle even with `oe_n` low. A later read in the same selection drives.
- R9: `wdata_q` takes `wdata` on every edge that registers a write and holds its value otherwise.
- R10: With `word_wr_n` high, `byte_wr_n` low and all lane selects high, the cycle is a write with no lane strobe, and `drive_en` is still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | A new external address is loaded this cycle, and `cs_n` is sampled |
| cs_n | input | 1 | Combined chip select, active low, used only with `addr_load` |
| word_wr_n | input | 1 | Whole-word write request, active low |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | 4 | Per-lane byte select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 36 | Write word: data bits 31:0, parity bits 35:32 |
| lane_we | output | 4 | Registered lane write strobes |
| bit_we | output | 36 | Registered per-bit write enable |
| wdata_q | output | 36 | Registered write word |
| drive_en | output | 1 | Data pin driver enable |

## Verification
The bench goes after the override of the lane selects by a whole-word write. A design that gives priority to the selects would drop lanes in R2. It checks that parity bits follow their own lane. A swapped or shifted parity mapping would corrupt the wrong byte's parity. It drives reads straight after a deselect, after a write, and after a deselect that is reached while `addr_load` stays low. A design that lets the drivers on in those cycles would fight the bus. It also toggles `oe_n` between clock edges to catch an enable that waits for the clock, and it includes the byte-write case with no lanes selected. A design that treats that case as a read would turn the drivers on during a write.

// File: rtl/bwdc_pkg.sv
package bwdc_pkg;
  localparam int unsigned DEF_LANES     = 4;
  localparam int unsigned DEF_LANE_BITS = 8;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;

  // Word width for a given lane geometry: data bits then one parity bit per lane.
  function automatic int unsigned word_width(int unsigned lanes, int unsigned lane_bits);
    return lanes * (lane_bits + 1);
  endfunction
endpackage

// File: rtl/bwdc_select_track.sv
module bwdc_select_track (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_load,
  input  logic cs_n,
  output logic sel_next,
  output logic sel_q
);
  // Selection is sampled only when a new address is loaded.
  always_comb sel_next = addr_load ? ~cs_n : sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_next;
  end
endmodule

// File: rtl/bwdc_lane_decode.sv
module bwdc_lane_decode #(
  parameter int unsigned LANES     = bwdc_pkg::DEF_LANES,
  parameter int unsigned LANE_BITS = bwdc_pkg::DEF_LANE_BITS,
  localparam int unsigned WORD_W   = LANES * (LANE_BITS + 1),
  localparam int unsigned DATA_W   = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_next,
  input  logic              word_wr_n,
  input  logic              byte_wr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic [WORD_W-1:0] wdata,
  output logic              wr_req,
  output logic [LANES-1:0]  lane_we,
  output logic [WORD_W-1:0] bit_we,
  output logic [WORD_W-1:0] wdata_q
);
  logic [LANES-1:0] lane_d;

  // Either write control starts a write; the whole-word request wins over the selects.
  always_comb begin
    wr_req = sel_next & (~word_wr_n | ~byte_wr_n);
    lane_d = '0;
    if (sel_next) begin
      if (!word_wr_n)      lane_d = '1;
      else if (!byte_wr_n) lane_d = ~lane_sel_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_we <= '0;
      wdata_q <= '0;
    end else begin
      lane_we <= lane_d;
      if (wr_req) wdata_q <= wdata;
    end
  end

  // Each lane enables its data byte and its own parity bit in the upper field.
  for (genvar k = 0; k < LANES; k++) begin : g_lane_bits
    assign bit_we[k*LANE_BITS +: LANE_BITS] = {LANE_BITS{lane_we[k]}};
    assign bit_we[DATA_W + k]               = lane_we[k];
  end
endmodule

// File: rtl/bwdc_drive_gate.sv
module bwdc_drive_gate
  import bwdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_next,
  input  logic sel_q,
  input  logic wr_req,
  input  logic oe_n,
  output logic drive_en
);
  cyc_kind_e kind_q;
  logic      first_q;
  cyc_kind_e kind_d;

  always_comb begin
    if (!sel_next)   kind_d = CYC_IDLE;
    else if (wr_req) kind_d = CYC_WRITE;
    else             kind_d = CYC_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= CYC_IDLE;
      first_q <= 1'b0;
    end else begin
      kind_q  <= kind_d;
      // Read that emerges from a deselected state: drivers held off one cycle.
      first_q <= (kind_d == CYC_READ) & ~sel_q;
    end
  end

  // The output enable acts combinationally; registered state only masks it.
  always_comb drive_en = ~oe_n & (kind_q == CYC_READ) & ~first_q;
endmodule

// File: rtl/byte_write_drive_ctrl.sv
module byte_write_drive_ctrl #(
  parameter int unsigned LANES     = bwdc_pkg::DEF_LANES,
  parameter int unsigned LANE_BITS = bwdc_pkg::DEF_LANE_BITS,
  localparam int unsigned WORD_W   = LANES * (LANE_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic              cs_n,
  input  logic              word_wr_n,
  input  logic              byte_wr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] wdata,
  output logic [LANES-1:0]  lane_we,
  output logic [WORD_W-1:0] bit_we,
  output logic [WORD_W-1:0] wdata_q,
  output logic              drive_en
);
  logic sel_next;
  logic sel_q;
  logic wr_req;

  bwdc_select_track u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_load (addr_load),
    .cs_n      (cs_n),
    .sel_next  (sel_next),
    .sel_q     (sel_q)
  );

  bwdc_lane_decode #(
    .LANES     (LANES),
    .LANE_BITS (LANE_BITS)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_next   (sel_next),
    .word_wr_n  (word_wr_n),
    .byte_wr_n  (byte_wr_n),
    .lane_sel_n (lane_sel_n),
    .wdata      (wdata),
    .wr_req     (wr_req),
    .lane_we    (lane_we),
    .bit_we     (bit_we),
    .wdata_q    (wdata_q)
  );

  bwdc_drive_gate u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_next (sel_next),
    .sel_q    (sel_q),
    .wr_req   (wr_req),
    .oe_n     (oe_n),
    .drive_en (drive_en)
  );
endmodule

// File: rtl/byte_write_drive_ctrl_chk.sv
module byte_write_drive_ctrl_chk #(
  parameter int unsigned LANES     = 4,
  parameter int unsigned LANE_BITS = 8,
  localparam int unsigned WORD_W   = LANES * (LANE_BITS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_load,
  input logic              cs_n,
  input logic              word_wr_n,
  input logic              byte_wr_n,
  input logic [LANES-1:0]  lane_sel_n,
  input logic              oe_n,
  input logic              sel_q,
  input logic [LANES-1:0]  lane_we,
  input logic [WORD_W-1:0] bit_we,
  input logic              drive_en
);
  AST_WORD_WRITE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load && !cs_n && !word_wr_n) |=> (lane_we == '1)); // R2

  AST_BYTE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load && !cs_n && word_wr_n && !byte_wr_n) |=> (lane_we == ~$past(lane_sel_n))); // R3

  AST_OE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drive_en); // R5

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load && !cs_n && !word_wr_n) |=> !drive_en); // R6

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load && cs_n) |=> (!drive_en && lane_we == '0)); // R7

  AST_FIRST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load && !cs_n && word_wr_n && byte_wr_n && !sel_q) |=> !drive_en); // R8

  always_comb begin
    if (rst_n) begin
      for (int k = 0; k < LANES; k++) begin
        AST_PARITY_FOLLOWS_LANE: assert (bit_we[LANES*LANE_BITS + k] == lane_we[k]); // R4
      end
    end
  end
endmodule

bind byte_write_drive_ctrl byte_write_drive_ctrl_chk #(
  .LANES     (LANES),
  .LANE_BITS (LANE_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_load  (addr_load),
  .cs_n       (cs_n),
  .word_wr_n  (word_wr_n),
  .byte_wr_n  (byte_wr_n),
  .lane_sel_n (lane_sel_n),
  .oe_n       (oe_n),
  .sel_q      (sel_q),
  .lane_we    (lane_we),
  .bit_we     (bit_we),
  .drive_en   (drive_en)
);

// File: tb/byte_write_drive_ctrl_tb.sv
module byte_write_drive_ctrl_tb;
  localparam int LN = 4;
  localparam int LB = 8;
  localparam int W  = LN * (LB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_load = 1'b0, cs_n = 1'b1, word_wr_n = 1'b1, byte_wr_n = 1'b1, oe_n = 1'b1;
  logic [LN-1:0] lane_sel_n = '1;
  logic [W-1:0]  wdata = '0;
  logic [LN-1:0] lane_we;
  logic [W-1:0]  bit_we, wdata_q;
  logic          drive_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference state
  bit           m_sel = 0, e_wr = 0, e_rd = 0, e_first = 0;
  logic [LN-1:0] e_lanes = '0;
  logic [W-1:0]  e_wd = '0;

  always #5 clk = ~clk;

  byte_write_drive_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .cs_n(cs_n),
    .word_wr_n(word_wr_n), .byte_wr_n(byte_wr_n), .lane_sel_n(lane_sel_n),
    .oe_n(oe_n), .wdata(wdata), .lane_we(lane_we), .bit_we(bit_we),
    .wdata_q(wdata_q), .drive_en(drive_en)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_bits(input logic [LN-1:0] l);
    logic [W-1:0] b = '0;
    for (int k = 0; k < LN; k++) begin
      for (int i = 0; i < LB; i++) b[k*LB+i] = l[k];
      b[LN*LB+k] = l[k];
    end
    return b;
  endfunction

  function automatic bit exp_drive(input logic oe);
    return !oe && e_rd && !e_first;
  endfunction

  function automatic string drive_tag();
    if (e_wr) return "R6 write masks drive";
    if (!m_sel) return "R7 deselected";
    if (e_first) return "R8 first read after deselect";
    return "R5 output enable";
  endfunction

  task automatic compare_all();
    chk("R2 R3 lane strobes", 64'(lane_we), 64'(e_lanes));
    chk("R4 bit enables", 64'(bit_we), 64'(exp_bits(e_lanes)));
    chk("R9 write data", 64'(wdata_q), 64'(e_wd));
    chk(drive_tag(), 64'(drive_en), 64'(exp_drive(oe_n)));
    // R5: toggle the output enable between edges, expect an immediate response
    oe_n = ~oe_n;
    #1;
    chk(drive_tag(), 64'(drive_en), 64'(exp_drive(oe_n)));
    oe_n = ~oe_n;
    #1;
  endtask

  // One clock: inputs already set; update the reference at the edge, compare at the falling edge.
  task automatic step();
    bit nsel;
    @(posedge clk);
    nsel = addr_load ? !cs_n : m_sel;
    e_wr = nsel && (!word_wr_n || !byte_wr_n);
    if (!nsel)           e_lanes = '0;
    else if (!word_wr_n) e_lanes = '1;
    else if (!byte_wr_n) e_lanes = ~lane_sel_n;
    else                 e_lanes = '0;
    e_rd    = nsel && !e_wr;
    e_first = e_rd && !m_sel;
    if (e_wr) e_wd = wdata;
    m_sel = nsel;
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(input bit ld, input bit cs, input bit gw, input bit bw,
                       input logic [LN-1:0] bs, input bit oe, input logic [W-1:0] d);
    addr_load = ld; cs_n = cs; word_wr_n = gw; byte_wr_n = bw;
    lane_sel_n = bs; oe_n = oe; wdata = d;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    oe_n = 1'b0;
    #1;
    chk("R1 reset strobes", 64'(lane_we), 64'd0);
    chk("R1 reset bits", 64'(bit_we), 64'd0);
    chk("R1 reset drive", 64'(drive_en), 64'd0);
    rst_n = 1'b1;

    // R8: read right after deselect is masked, the next read drives
    drive(1, 0, 1, 1, 4'hF, 0, 36'h0);
    chk("R8 first read masked", 64'(drive_en), 64'd0);
    drive(1, 0, 1, 1, 4'hF, 0, 36'h0);
    chk("R5 second read drives", 64'(drive_en), 64'd1);
    // R2: word write overrides selects and byte enable
    drive(1, 0, 0, 1, 4'hF, 0, 36'hA_5A5A_5A5A);
    chk("R2 all lanes", 64'(lane_we), 64'hF);
    chk("R6 write drive off", 64'(drive_en), 64'd0);
    // R3: byte writes with several patterns, selection held (addr_load low)
    drive(0, 1, 1, 0, 4'b1010, 0, 36'h1_2345_6789);
    chk("R3 lanes 0 and 2", 64'(lane_we), 64'h5);
    drive(0, 1, 1, 0, 4'b0111, 0, 36'h8_FEDC_BA98);
    chk("R4 parity lane 3", 64'(bit_we[35]), 64'd1);
    // R10: byte write with no lane selected still masks drive
    drive(0, 1, 1, 0, 4'hF, 0, 36'h7_0000_0001);
    chk("R10 no lanes", 64'(lane_we), 64'd0);
    chk("R10 drive off", 64'(drive_en), 64'd0);
    chk("R9 data captured", 64'(wdata_q), 64'h7_0000_0001);
    // read after write (selection held): not first, drives
    drive(0, 1, 1, 1, 4'h0, 0, 36'h0);
    chk("R9 data held on read", 64'(wdata_q), 64'h7_0000_0001);
    // R7: deselect, write attempts ignored, then held deselect with addr_load low
    drive(1, 1, 0, 0, 4'h0, 0, 36'h3_3333_3333);
    chk("R7 deselect no strobes", 64'(lane_we), 64'd0);
    drive(0, 0, 0, 0, 4'h0, 0, 36'h3_3333_3333);
    chk("R7 held deselect", 64'(drive_en), 64'd0);
    chk("R9 ignored when deselected", 64'(wdata_q), 64'h7_0000_0001);
    drive(1, 0, 1, 1, 4'hF, 0, 36'h0);
    chk("R8 read after held deselect", 64'(drive_en), 64'd0);

    // Mixed stimulus, compared on every clock against the reference
    for (int n = 0; n < 400; n++) begin
      drive(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0),
            1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) == 0),
            4'($urandom), 1'($urandom_range(0, 3) == 0),
            {4'($urandom), 32'($urandom)});
    end

    // Reset mid-operation returns to the deselected state
    drive(1, 0, 0, 1, 4'hF, 0, 36'h1);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset strobes", 64'(lane_we), 64'd0);
    chk("R1 async reset drive", 64'(drive_en), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule